// File: doc/BRIEF.md
# Programmable Two-Stage Clock Divider

This block derives two slower clock rates from one fast external clock without creating any new clock domain. A first stage divides the external clock by an integer from one to five and produces the internal master rate. A second stage counts internal-rate ticks and divides them by eight, four, two or one to produce the serial bit rate. Both ratios come from one 8-bit control byte: a 3-bit field selects the first ratio and a 2-bit field selects the second.

Each stage provides a one-cycle enable pulse for logic that runs on the external clock, and a level that looks like the divided clock. The serial stage also provides strobes that mark the cycle before its level rises or falls. A shifter can use these strobes to launch or capture data. A ratio change waits for the terminal count of the affected counter, so no output ever shows a shortened phase.

Top module: `clk_div_top`

## Requirements
- R1: Control bits 6:4 select the first-stage ratio. Codes 000, 001, 010, 011 and 100 make `dmclk_en_o` pulse once every 1, 2, 3, 4 and 5 clock cycles.
- R2: First-stage codes 101, 110 and 111 divide by one.
- R3: While reset is low and after it is released, the first stage divides by one and the second stage divides by eight. In reset, `dmclk_en_o`, `dmclk_o` and `sclk_o` are 1 and `sclk_en_o`, `sclk_rise_o` and `sclk_fall_o` are 0.
- R4: Control bits 3:2 select the second-stage ratio in dmclk_en pulses: 00 is /8, 01 is /4, 10 is /2 and 11 is /1.
- R5: At second-stage /1, `sclk_en_o` equals `dmclk_en_o` and `sclk_o` equals `dmclk_o`.
- R6: `sclk_en_o` is high only in cycles where `dmclk_en_o` is high.
- R7: For a ratio N of 2 or more, the divided level is high for floor(N/2) units and low for ceil(N/2) units. The unit is clock cycles for `dmclk_o` and dmclk_en pulses for `sclk_o`. `dmclk_o` is high in the cycle after each `dmclk_en_o` pulse.
- R8: A new ratio takes effect only at the terminal count of its stage, which is the cycle in which that stage's enable pulse is high. The field value sampled at that edge sets the length of the following period.
- R9: At first-stage /1, `dmclk_en_o` and `dmclk_o` stay high.
- R10: `sclk_rise_o` is high in the cycle before `sclk_o` goes high and coincides with `sclk_en_o`. `sclk_fall_o` is high in the cycle before `sclk_o` goes low. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_b_i | input | 8 | Control byte: bits 6:4 first ratio, bits 3:2 serial ratio |
| dmclk_en_o | output | 1 | One-cycle enable at the internal master rate |
| dmclk_o | output | 1 | Internal master clock level |
| sclk_en_o | output | 1 | One-cycle enable at the serial rate |
| sclk_o | output | 1 | Serial clock level |
| sclk_rise_o | output | 1 | Strobe in the cycle before `sclk_o` rises |
| sclk_fall_o | output | 1 | Strobe in the cycle before `sclk_o` falls |

## Verification
Every legal first-stage code is run with the slowest serial ratio. This separates the even and odd ratios and shows the uneven duty of ratios 3 and 5. The three unused codes are run after a non-unity ratio, so a fallback that is not divide-by-one shows up. All four serial codes are run over first-stage ratios 2 and 3, which separates the /1 mirror path from the counted path. Rapid control changes in the middle of a period show whether a new ratio is taken before the terminal count.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned MCD_LSB   = 4;
  localparam int unsigned MCD_W     = 3;
  localparam int unsigned MCD_MAX   = 5;
  localparam int unsigned SCD_LSB   = 2;
  localparam int unsigned SCD_W     = 2;
  localparam int unsigned SCD_STEPS = 1 << SCD_W;
  localparam int unsigned SCD_MAX   = 1 << (SCD_STEPS - 1);
  localparam int unsigned MCD_CNT_W = $clog2(MCD_MAX);
  localparam int unsigned SCD_CNT_W = $clog2(SCD_MAX);

  // terminal count = ratio - 1; unused codes fall back to ratio 1
  function automatic logic [MCD_CNT_W-1:0] mcd_term(input logic [MCD_W-1:0] code);
    if (int'(code) < int'(MCD_MAX)) return MCD_CNT_W'(code);
    return '0;
  endfunction

  // code 0 is slowest, highest code is /1
  function automatic logic [SCD_CNT_W-1:0] scd_term(input logic [SCD_W-1:0] code);
    int sh;
    sh = int'(SCD_STEPS) - 1 - int'(code);
    return SCD_CNT_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/clk_div_decode.sv
module clk_div_decode
  import clk_div_pkg::*;
(
  input  logic [CTRL_W-1:0]    ctrl_i,
  output logic [MCD_CNT_W-1:0] mcd_term_o,
  output logic [SCD_CNT_W-1:0] scd_term_o
);
  logic [MCD_W-1:0] mcd_code;
  logic [SCD_W-1:0] scd_code;

  assign mcd_code   = ctrl_i[MCD_LSB +: MCD_W];
  assign scd_code   = ctrl_i[SCD_LSB +: SCD_W];
  assign mcd_term_o = mcd_term(mcd_code);
  assign scd_term_o = scd_term(scd_code);
endmodule

// File: rtl/clk_div_stage.sv
module clk_div_stage #(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned RST_TERM = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] term_nxt_i,
  output logic             tick_o,
  output logic             level_o,
  output logic             mid_o,
  output logic             bypass_o
);
  logic [CNT_W-1:0] cnt_q, term_q;
  logic [CNT_W:0]   half_w, cnt_inc;
  logic             wrap;

  assign wrap    = (cnt_q == term_q);
  assign half_w  = ({1'b0, term_q} + (CNT_W+1)'(1)) >> 1;
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_q <= CNT_W'(RST_TERM);
    end else if (adv_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        term_q <= term_nxt_i;  // ratio swap only at terminal count
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign bypass_o = (term_q == '0);
  assign tick_o   = adv_i & wrap;
  assign level_o  = bypass_o | ({1'b0, cnt_q} < half_w);
  assign mid_o    = adv_i & ~bypass_o & (cnt_inc == half_w);
endmodule

// File: rtl/clk_div_top.sv
module clk_div_top
  import clk_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_b_i,
  output logic              dmclk_en_o,
  output logic              dmclk_o,
  output logic              sclk_en_o,
  output logic              sclk_o,
  output logic              sclk_rise_o,
  output logic              sclk_fall_o
);
  logic [MCD_CNT_W-1:0] mcd_nxt;
  logic [SCD_CNT_W-1:0] scd_nxt;
  logic m_tick, m_level, m_mid, m_bypass;
  logic s_tick, s_level, s_mid, s_bypass;

  clk_div_decode u_dec (
    .ctrl_i     (ctrl_b_i),
    .mcd_term_o (mcd_nxt),
    .scd_term_o (scd_nxt)
  );

  clk_div_stage #(.CNT_W(MCD_CNT_W), .RST_TERM(0)) u_mstage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (1'b1),
    .term_nxt_i (mcd_nxt),
    .tick_o     (m_tick),
    .level_o    (m_level),
    .mid_o      (m_mid),
    .bypass_o   (m_bypass)
  );

  clk_div_stage #(.CNT_W(SCD_CNT_W), .RST_TERM(SCD_MAX-1)) u_sstage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (m_tick),
    .term_nxt_i (scd_nxt),
    .tick_o     (s_tick),
    .level_o    (s_level),
    .mid_o      (s_mid),
    .bypass_o   (s_bypass)
  );

  assign dmclk_en_o  = m_tick;
  assign dmclk_o     = m_level | m_bypass;
  assign sclk_en_o   = s_tick;
  // serial /1 mirrors the internal clock, including its falling strobe
  assign sclk_o      = s_bypass ? dmclk_o : s_level;
  assign sclk_rise_o = s_tick;
  assign sclk_fall_o = s_bypass ? m_mid : s_mid;
endmodule

// File: rtl/clk_div_checker.sv
module clk_div_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic dmclk_en_o,
  input logic dmclk_o,
  input logic sclk_en_o,
  input logic sclk_o,
  input logic sclk_rise_o,
  input logic sclk_fall_o
);
  assert_sclk_en_nested_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en_o |-> dmclk_en_o);

  assert_dmclk_high_after_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmclk_en_o |=> dmclk_o);

  assert_strobes_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_rise_o && sclk_fall_o));

  assert_rise_with_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_o |-> sclk_en_o);

  assert_rise_leads_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_o |=> sclk_o);

  assert_fall_leads_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall_o |=> !sclk_o);

  assert_fell_announced_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $past(sclk_fall_o));
endmodule

bind clk_div_top clk_div_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dmclk_en_o  (dmclk_en_o),
  .dmclk_o     (dmclk_o),
  .sclk_en_o   (sclk_en_o),
  .sclk_o      (sclk_o),
  .sclk_rise_o (sclk_rise_o),
  .sclk_fall_o (sclk_fall_o)
);

// File: tb/sim_clk_div_top.sv
`timescale 1ns/1ps
module sim_clk_div_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ctrl_b_i = 8'h00;
  logic dmclk_en_o, dmclk_o, sclk_en_o, sclk_o, sclk_rise_o, sclk_fall_o;

  always #2.5 clk_i = ~clk_i;

  clk_div_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_b_i(ctrl_b_i),
    .dmclk_en_o(dmclk_en_o), .dmclk_o(dmclk_o), .sclk_en_o(sclk_en_o),
    .sclk_o(sclk_o), .sclk_rise_o(sclk_rise_o), .sclk_fall_o(sclk_fall_o)
  );

  typedef struct {
    logic [5:0] v;
    string      tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state: phase and ratio of each stage
  int p1, n1, p2, m2;
  logic [7:0] cur_c;

  function automatic int ratio1(input logic [7:0] c);
    int code;
    code = int'(c[6:4]);
    return (code <= 4) ? code + 1 : 1;
  endfunction

  function automatic int ratio2(input logic [7:0] c);
    case (c[3:2])
      2'b00:   return 8;
      2'b01:   return 4;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  task automatic model_reset();
    p1 = 0; n1 = 1; p2 = 0; m2 = 8;
  endtask

  task automatic model_step();
    bit w1;
    w1 = (p1 == n1 - 1);
    if (w1) begin
      if (p2 == m2 - 1) begin p2 = 0; m2 = ratio2(cur_c); end
      else p2++;
      p1 = 0; n1 = ratio1(cur_c);
    end else begin
      p1++;
    end
  endtask

  task automatic push_exp(input string tag);
    item_t it;
    logic e1, d, e2, s, r, f;
    e1 = (p1 == n1 - 1);
    d  = (n1 == 1) ? 1'b1 : (p1 < n1 / 2);
    e2 = e1 && (p2 == m2 - 1);
    s  = (m2 == 1) ? d : (p2 < m2 / 2);
    r  = e2;
    f  = (m2 == 1) ? (n1 > 1 && p1 == n1 / 2 - 1) : (e1 && p2 == m2 / 2 - 1);
    it.v   = {e1, d, e2, s, r, f};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input logic [7:0] c, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      model_step();
      push_exp(tag);
      cur_c    = c;
      ctrl_b_i = c;
    end
  endtask

  // monitor: compare each expected item against the ports
  initial begin
    string names[6];
    names = '{"dmclk_en_o", "dmclk_o", "sclk_en_o", "sclk_o", "sclk_rise_o", "sclk_fall_o"};
    forever begin
      @(negedge clk_i);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [5:0] act;
        it  = q.pop_front();
        act = {dmclk_en_o, dmclk_o, sclk_en_o, sclk_o, sclk_rise_o, sclk_fall_o};
        total++;
        if (act !== it.v) begin
          bad++;
          for (int b = 0; b < 6; b++)
            if (act[5-b] !== it.v[5-b])
              $display("FAIL %s %s act=%b exp=%b", it.tag, names[b], act[5-b], it.v[5-b]);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    cur_c = 8'h00;
    // R3: outputs held during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      push_exp("R3 reset");
    end
    rst_ni = 1'b1;
    // R3 R9: defaults after reset, /1 then /8
    run(8'h00, 20, "R3 R9 default");
    // R1 R7 R8: every legal first-stage code, slowest serial rate
    run(8'h10, 40, "R1 R7 R8 div2");
    run(8'h20, 60, "R1 R7 R8 div3");
    run(8'h30, 70, "R1 R7 R8 div4");
    run(8'h40, 90, "R1 R7 R8 div5");
    // R2: unused codes behave as /1
    run(8'h50, 20, "R2 R9 code5");
    run(8'h40, 12, "R2 R8 back5");
    run(8'h60, 20, "R2 R9 code6");
    run(8'h30, 10, "R2 R8 back4");
    run(8'h70, 20, "R2 R9 code7");
    // R4 R5 R6: serial codes over /2
    run(8'h14, 40, "R4 R6 div2 s4");
    run(8'h18, 30, "R4 R7 div2 s2");
    run(8'h1C, 30, "R5 R6 div2 s1");
    // R4 R5 R7 R10: serial codes over /3
    run(8'h28, 40, "R4 R7 R10 div3 s2");
    run(8'h2C, 30, "R5 R10 div3 s1");
    run(8'h24, 50, "R4 R10 div3 s4");
    run(8'h0C, 10, "R5 R9 div1 s1");
    // R8: changes in the middle of periods
    for (int k = 0; k < 12; k++)
      run(8'((k % 5) << 4) | 8'((k % 4) << 2), 3 + (k % 4), "R8 R6 midchange");
    run(8'h40, 80, "R8 R7 settle");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule